// File: doc/BRIEF.md
# Seedable Lockup-Safe Linear Feedback Shift Register

This block produces a pseudo-random sequence from a linear feedback shift register. The parameters choose the Fibonacci or the Galois arrangement, an XOR or an XNOR feedback sense, the tap mask, and the number of register steps taken per increment. Each increment advances the state by the feedback function `STEP` times within one clock cycle. The whole state appears on a parallel output.

Each state bit is a flip-flop of its own. Only the asynchronous reset can load those flip-flops with a constant, and a value computed at run time is never used. When `HAS_SEED` is 0, only bit 0 has a reset. Reset forces that bit to the value that moves the register away from its lockup state. The other bits have no reset, which keeps the reset fanout small. When `HAS_SEED` is 1, reset loads every bit from the `SEED` parameter.

A seed port can overwrite the whole state at run time with any value, including the lockup value. Once locked up, the register stays at that value until a reset or a new seed load.

Top module: `lfsr_gen`

## Requirements
- R1: With `HAS_SEED`=0, reset forces bit 0 to 1 for XOR feedback and to 0 for XNOR feedback. After reset the state is never the lockup value, even if the register was locked up before the reset.
- R2: With `HAS_SEED`=1, reset loads `SEED` into every state bit.
- R3: When `seed_vld` is 1 at a rising clock edge, the state becomes `seed_data` at that edge.
- R4: A seed load takes priority over an increment in the same cycle. The state becomes `seed_data` and is not advanced.
- R5: When `step_en` is 1 and `seed_vld` is 0, the state advances by the one-step function applied `STEP` times. When both are 0, the state holds.
- R6: One Fibonacci XOR step, with `GALOIS`=0 and `XNOR`=0, gives `{s[W-2:0], parity(s & TAPS)}`. The new bit enters at bit 0.
- R7: One Galois XOR step, with `GALOIS`=1 and `XNOR`=0, gives `(s >> 1) ^ (s[0] ? TAPS : 0)`. `TAPS[W-1]` must be 1.
- R8: With `XNOR`=1, one step is the bitwise complement of the XOR step applied to the complemented state. Its lockup value is all ones. With `XNOR`=0 the lockup value is all zeros.
- R9: If the state holds the lockup value, it keeps that value on every later increment.
- R10: With maximal-length taps, each increment changes the state out of any non-lockup value. With `STEP`=1 the state returns to its start after exactly 2^W-1 increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| arst | input | 1 | Asynchronous reset, active high |
| step_en | input | 1 | Advance the state by `STEP` feedback steps |
| seed_vld | input | 1 | Load `seed_data` into the state |
| seed_data | input | WIDTH | Value to load into the state |
| state_out | output | WIDTH | Current state |

## Verification
A seed load and an increment can fall in the same cycle. The bench provokes this by raising `seed_vld` and `step_en` together, once for every possible seed value on two configurations. The state after that edge must equal the seed exactly and must show no step of the feedback function. A second pass loads each seed alone and then increments once. The bench compares the result with an arithmetic model of the selected feedback form.

// File: rtl/lfsr_gen.sv
module lfsr_gen #(
  parameter int              WIDTH    = 8,
  parameter logic [WIDTH-1:0] TAPS    = 8'hB8,
  parameter bit              GALOIS   = 1'b0,
  parameter bit              XNOR     = 1'b0,
  parameter int              STEP     = 1,
  parameter bit              HAS_SEED = 1'b0,
  parameter logic [WIDTH-1:0] SEED    = '0
) (
  input  logic             clk,
  input  logic             arst,
  input  logic             step_en,
  input  logic             seed_vld,
  input  logic [WIDTH-1:0] seed_data,
  output logic [WIDTH-1:0] state_out
);
  localparam logic RST_BIT0 = ~XNOR;

  function automatic logic [WIDTH-1:0] one_step(input logic [WIDTH-1:0] s);
    logic [WIDTH-1:0] t;
    t = XNOR ? ~s : s;
    if (GALOIS) t = (t >> 1) ^ ({WIDTH{t[0]}} & TAPS);
    else        t = {t[WIDTH-2:0], ^(t & TAPS)};
    return XNOR ? ~t : t;
  endfunction

  logic [WIDTH-1:0] advanced, next_state;
  logic             load;

  always_comb begin
    advanced = state_out;
    for (int k = 0; k < STEP; k++) advanced = one_step(advanced);
  end

  assign load       = seed_vld | step_en;
  assign next_state = seed_vld ? seed_data : advanced;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic q;
    if (HAS_SEED) begin : g_seeded
      always_ff @(posedge clk or posedge arst)
        if (arst)      q <= SEED[i];
        else if (load) q <= next_state[i];
    end else if (i == 0) begin : g_escape
      always_ff @(posedge clk or posedge arst)
        if (arst)      q <= RST_BIT0;
        else if (load) q <= next_state[i];
    end else begin : g_plain
      always_ff @(posedge clk)
        if (load) q <= next_state[i];
    end
    assign state_out[i] = q;
  end
endmodule

// File: rtl/lfsr_gen_chk.sv
module lfsr_gen_chk #(
  parameter int               WIDTH    = 8,
  parameter bit               XNOR     = 1'b0,
  parameter bit               HAS_SEED = 1'b0,
  parameter logic [WIDTH-1:0] SEED     = '0,
  parameter bit               MAXLEN   = 1'b1
) (
  input logic             clk,
  input logic             arst,
  input logic             step_en,
  input logic             seed_vld,
  input logic [WIDTH-1:0] seed_data,
  input logic [WIDTH-1:0] state_out
);
  localparam logic [WIDTH-1:0] LOCK = XNOR ? '1 : '0;

  a_r1_escape: assert property (@(posedge clk) disable iff (arst)
    ($fell(arst) && !HAS_SEED) |-> (state_out != LOCK && state_out[0] == ~XNOR));

  a_r2_seed_reset: assert property (@(posedge clk) disable iff (arst)
    ($fell(arst) && HAS_SEED) |-> state_out == SEED);

  a_r4_seed_priority: assert property (@(posedge clk) disable iff (arst)
    seed_vld |=> state_out == $past(seed_data));

  a_r5_hold: assert property (@(posedge clk) disable iff (arst)
    (!seed_vld && !step_en) |=> $stable(state_out));

  a_r9_lockup: assert property (@(posedge clk) disable iff (arst)
    (state_out == LOCK && !seed_vld) |=> state_out == LOCK);

  a_r10_moves: assert property (@(posedge clk) disable iff (arst)
    (MAXLEN && step_en && !seed_vld && state_out != LOCK) |=> state_out != $past(state_out));
endmodule

bind lfsr_gen lfsr_gen_chk #(
  .WIDTH(WIDTH), .XNOR(XNOR), .HAS_SEED(HAS_SEED), .SEED(SEED), .MAXLEN(1'b1)
) chk_i (.*);

// File: tb/lfsr_gen_tb_top.sv
module lfsr_gen_tb_top;
  localparam int   CLK_PERIOD = 10;
  localparam logic [7:0] TAPS = 8'hB8;
  localparam logic [7:0] SEEDB = 8'h5A;

  logic clk = 1'b0;
  logic arst = 1'b0;
  logic a_step = 1'b0, a_seed = 1'b0, b_step = 1'b0, b_seed = 1'b0;
  logic [7:0] a_data = '0, b_data = '0;
  logic [7:0] a_out, b_out;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lfsr_gen #(.WIDTH(8), .TAPS(TAPS), .GALOIS(1'b0), .XNOR(1'b0), .STEP(1), .HAS_SEED(1'b0))
    dut_i (.clk(clk), .arst(arst), .step_en(a_step), .seed_vld(a_seed),
           .seed_data(a_data), .state_out(a_out));

  lfsr_gen #(.WIDTH(8), .TAPS(TAPS), .GALOIS(1'b1), .XNOR(1'b1), .STEP(3), .HAS_SEED(1'b1), .SEED(SEEDB))
    dut2_i (.clk(clk), .arst(arst), .step_en(b_step), .seed_vld(b_seed),
            .seed_data(b_data), .state_out(b_out));

  function automatic int fib_x(int s);
    return ((s * 2) % 256) + ($countones(s[7:0] & TAPS) % 2);
  endfunction

  function automatic int gal_x(int s);
    return (s / 2) ^ (((s % 2) == 1) ? int'(TAPS) : 0);
  endfunction

  function automatic int b_model(int s);
    int t = s;
    for (int k = 0; k < 3; k++) t = 255 - gal_x(255 - t);
    return t;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    arst = 1'b1; #(CLK_PERIOD*2); arst = 1'b0; tick();
  endtask

  initial begin
    int start, prev;
    a_step = 1'b0; a_seed = 1'b0; b_step = 1'b0; b_seed = 1'b0;
    tick();
    do_reset();
    check(a_out[0] == 1'b1 && a_out != 8'h00, "R1 reset bit0", a_out, 1);
    check(b_out == SEEDB, "R2 seed reset", b_out, SEEDB);

    for (int s = 0; s < 256; s++) begin
      a_data = s[7:0]; a_seed = 1'b1; a_step = 1'b1;
      b_data = s[7:0]; b_seed = 1'b1; b_step = 1'b1;
      tick();
      check(a_out == s[7:0], "R4 A seed over step", a_out, s);
      check(b_out == s[7:0], "R4 B seed over step", b_out, s);
      a_seed = 1'b0; b_seed = 1'b0;
      tick();
      if (s == 0) check(a_out == 8'h00, "R9 A lockup", a_out, 0);
      else        check(a_out == fib_x(s), "R6 fib step", a_out, fib_x(s));
      if (s == 255) check(b_out == 8'hFF, "R9 B lockup", b_out, 255);
      else          check(b_out == b_model(s), "R7 R8 galois xnor step", b_out, b_model(s));
    end

    a_step = 1'b0; b_step = 1'b0;
    a_data = 8'h3C; a_seed = 1'b1; b_data = 8'hC3; b_seed = 1'b1;
    tick();
    check(a_out == 8'h3C, "R3 A seed load", a_out, 8'h3C);
    check(b_out == 8'hC3, "R3 B seed load", b_out, 8'hC3);
    a_seed = 1'b0; b_seed = 1'b0;
    a_data = 8'hFF; b_data = 8'h00;
    for (int i = 0; i < 4; i++) begin
      tick();
      check(a_out == 8'h3C, "R5 A hold", a_out, 8'h3C);
      check(b_out == 8'hC3, "R5 B hold", b_out, 8'hC3);
    end

    start = a_out; a_step = 1'b1;
    for (int i = 1; i <= 255; i++) begin
      prev = a_out;
      tick();
      check(a_out == fib_x(prev), "R5 R6 sequence", a_out, fib_x(prev));
      check(a_out != prev[7:0], "R10 changes", a_out, prev);
      if (i < 255) check(a_out != start[7:0], "R10 no early repeat", a_out, start);
    end
    check(a_out == start[7:0], "R10 period 255", a_out, start);
    a_step = 1'b0;

    a_data = 8'h00; a_seed = 1'b1; tick(); a_seed = 1'b0; a_step = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick();
      check(a_out == 8'h00, "R9 lockup after seed", a_out, 0);
    end
    b_data = 8'hFF; b_seed = 1'b1; tick(); b_seed = 1'b0; b_step = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick();
      check(b_out == 8'hFF, "R9 B lockup after seed", b_out, 255);
    end
    a_step = 1'b0; b_step = 1'b0;
    do_reset();
    check(a_out != 8'h00 && a_out[0] == 1'b1, "R1 escape from lockup", a_out, 1);
    check(b_out == SEEDB, "R2 reset after lockup", b_out, SEEDB);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule